// File: doc/BRIEF.md
# LPC target to Wishbone bridge

This block sits on the peripheral side of a Low Pin Count bus. It watches an active-high frame strobe and a 4-bit LAD bus, which has a separate input, output and output enable. It decodes memory, I/O and firmware cycles and turns each one into exactly one Wishbone master access: 32-bit address, 32-bit data, byte selects and a 2-bit cycle tag. While the access is outstanding, the block holds the host in the sync phase. It then answers with ready or error and, for reads, returns the captured word one nibble at a time.

The controller is a single enumerated state machine:

- **IDLE** waits for a start nibble.
- **CTYPE** takes the cycle-type nibble of a generic cycle.
- **ADDR** shifts in the address nibbles.
- **SIZE** takes the firmware size nibble.
- **HDATA** collects host write data.
- **HTAR1** and **HTAR2** are the two host turnaround clocks.
- **SYNC** drives long-wait, ready or error.
- **RDATA** drives read nibbles.
- **PTAR** is the one-clock target turnaround.

The transitions are:

- IDLE→CTYPE on a generic start.
- IDLE→ADDR on a firmware start.
- CTYPE→ADDR.
- ADDR→SIZE when the last address nibble arrives in a firmware cycle, or ADDR→HDATA or HTAR1 in a generic cycle.
- SIZE→HDATA for a write, or SIZE→HTAR1 for a read.
- HDATA→HTAR1 after the last data nibble.
- HTAR1→HTAR2→SYNC.
- SYNC→RDATA when a read is answered ready.
- SYNC→PTAR when a write is answered or on an error.
- RDATA→SYNC between bytes, or RDATA→PTAR after the last byte.
- PTAR→IDLE.

Any frame clock outside IDLE aborts the cycle and re-decodes the start nibble on that same clock.

The Wishbone strobe and cycle rise on the clock after the last host nibble, and stay up until acknowledge or error. The response is latched. SYNC reports it in its first clock at or after the clock in which the response was sampled.

Top module: `lpc_tgt_bridge`

## Requirements
- R1: While reset is asserted, and after it is released, the LAD output enable, Wishbone cycle and Wishbone strobe are all low.
- R2: With the frame strobe high, these LAD values start a cycle: 0000 starts a generic cycle, 1101 a firmware read and 1110 a firmware write. Any other nibble, including 1111, starts nothing and leaves the block idle with the output enable and cycle low.
- R3: In a generic cycle, the nibble after start is the cycle type. Bit 2 set selects memory (tag 00) and bit 2 clear selects I/O (tag 01). Bit 1 set means write. Firmware cycles use tag 10 and take their direction from the start code. The write-enable output follows the decoded direction.
- R4: The address arrives most significant nibble first: 8 nibbles for memory and firmware cycles, 4 nibbles for I/O. The I/O address is zero-extended to 32 bits. The address, selects and tag stay stable while the access is outstanding.
- R5: A firmware cycle carries one size nibble after the address. 0 means one byte (select 0001), 1 means two bytes (0011) and 2 means four bytes (1111); any other value is treated as one byte. Memory and I/O cycles move one byte with select 0001.
- R6: Host write data arrives after the address (or size) nibble, low nibble first within each byte, bytes in ascending order. The Wishbone write data carries those bytes, with unused upper bytes at zero.
- R7: The output enable stays low from start through the second host turnaround clock. Cycle and strobe rise on the clock after the last host address, size or data nibble, and stay high until acknowledge or error, then drop on the next clock.
- R8: In SYNC the block drives 0110 while the access is pending. Once an acknowledge has been sampled it drives 0000; once an error has been sampled it drives 1010. The first SYNC clock already shows a response sampled during the turnaround.
- R9: After each ready sync of a read, the block drives two nibbles of the captured word, low nibble first, bytes in ascending order. Another ready sync separates consecutive bytes.
- R10: After a write's ready sync, after any error sync, or after the last read nibble, the block drives 1111 with the output enable high for one clock. It then releases LAD and is idle.
- R11: A frame clock in any non-idle state aborts the cycle. On the next clock, the output enable and Wishbone cycle are low and the start nibble of that clock has been decoded as a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame strobe, active high |
| lad_i | input | 4 | LAD input nibble |
| lad_o | output | 4 | LAD output nibble |
| lad_oe_o | output | 1 | LAD output enable |
| wb_adr_o | output | 32 | Wishbone address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_tga_o | output | 2 | Cycle tag: 00 memory, 01 I/O, 10 firmware |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error |

## Verification
The bench varies the acknowledge delay from zero upward. A design that reported the response one clock late would show an extra 0110 in front of the ready, and one that did not latch it would lose an acknowledge that lands during the turnaround. Multi-byte firmware reads check the ready sync between bytes and the byte order; a wrong nibble order or a missing inter-byte sync shows up as mismatched LAD values. Aborts with a stop nibble and with a fresh start, both mid-address and mid-sync, catch a design that leaves the Wishbone cycle hanging or that needs an extra idle clock before it can accept the new start.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_SIZE,
        ST_HDATA,
        ST_HTAR1,
        ST_HTAR2,
        ST_SYNC,
        ST_RDATA,
        ST_PTAR
    } lpc_state_e;

    localparam logic [3:0] NIB_GEN_START = 4'b0000;
    localparam logic [3:0] NIB_FW_RD     = 4'b1101;
    localparam logic [3:0] NIB_FW_WR     = 4'b1110;
    localparam logic [3:0] NIB_TAR       = 4'b1111;
    localparam logic [3:0] SYNC_READY    = 4'b0000;
    localparam logic [3:0] SYNC_LWAIT    = 4'b0110;
    localparam logic [3:0] SYNC_ERROR    = 4'b1010;

    localparam logic [1:0] TAG_MEM = 2'b00;
    localparam logic [1:0] TAG_IO  = 2'b01;
    localparam logic [1:0] TAG_FW  = 2'b10;

endpackage

// File: rtl/lpc_tgt_wbm.sv
module lpc_tgt_wbm #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          launch_i,
    input  logic          ack_i,
    input  logic          err_i,
    input  logic [DW-1:0] dat_i,
    output logic          cyc_o,
    output logic          stb_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] word_o
);

    logic          busy_q;
    logic          done_q;
    logic          err_q;
    logic [DW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            word_q <= '0;
        end else if (clr_i) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (launch_i) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (busy_q && (ack_i || err_i)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= err_i;
            if (!err_i) begin
                word_q <= dat_i;
            end
        end
    end

    assign cyc_o  = busy_q;
    assign stb_o  = busy_q;
    assign done_o = done_q;
    assign err_o  = err_q;
    assign word_o = word_q;

endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IO_ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [3:0]        lad_i,
    input  logic              rsp_done_i,
    input  logic              rsp_err_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe_o,
    output logic              launch_o,
    output logic [ADDR_W-1:0] adr_o,
    output logic [DATA_W-1:0] wdat_o,
    output logic [3:0]        sel_o,
    output logic [1:0]        tga_o,
    output logic              we_o
);

    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int IO_NIBS   = IO_ADDR_W / 4;
    localparam int MAX_BYTES = DATA_W / 8;
    localparam int DAT_NIBS  = 2 * MAX_BYTES;
    localparam int ACW       = $clog2(ADDR_NIBS + 1);
    localparam int DCW       = $clog2(DAT_NIBS);
    localparam int BCW       = $clog2(MAX_BYTES + 1);

    lpc_state_e        state_q, state_d;
    logic [ACW-1:0]    adr_left_q;
    logic [DCW-1:0]    dat_idx_q;
    logic [BCW-1:0]    nbytes_q;
    logic              is_fw_q;
    logic              is_mem_q;
    logic              we_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] wdat_q;

    logic              fw_code;
    logic              last_nib;
    logic [BCW:0]      nib_total;

    assign fw_code   = (lad_i == NIB_FW_RD) || (lad_i == NIB_FW_WR);
    assign nib_total = {nbytes_q, 1'b0};
    assign last_nib  = ((BCW+1)'(dat_idx_q) + (BCW+1)'(1)) == nib_total;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (frame_i) begin
            if (lad_i == NIB_GEN_START) begin
                state_d = ST_CTYPE;
            end else if (fw_code) begin
                state_d = ST_ADDR;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_CTYPE: state_d = ST_ADDR;
                ST_ADDR: begin
                    if (adr_left_q == ACW'(1)) begin
                        if (is_fw_q)   state_d = ST_SIZE;
                        else if (we_q) state_d = ST_HDATA;
                        else           state_d = ST_HTAR1;
                    end
                end
                ST_SIZE:  state_d = we_q ? ST_HDATA : ST_HTAR1;
                ST_HDATA: if (last_nib) state_d = ST_HTAR1;
                ST_HTAR1: state_d = ST_HTAR2;
                ST_HTAR2: state_d = ST_SYNC;
                ST_SYNC: begin
                    if (rsp_done_i) begin
                        state_d = (rsp_err_i || we_q) ? ST_PTAR : ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (dat_idx_q[0]) begin
                        state_d = last_nib ? ST_PTAR : ST_SYNC;
                    end
                end
                ST_PTAR:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // collected fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr_left_q <= '0;
            dat_idx_q  <= '0;
            nbytes_q   <= BCW'(1);
            is_fw_q    <= 1'b0;
            is_mem_q   <= 1'b0;
            we_q       <= 1'b0;
            adr_q      <= '0;
            wdat_q     <= '0;
        end else if (frame_i) begin
            adr_left_q <= ACW'(ADDR_NIBS);
            dat_idx_q  <= '0;
            nbytes_q   <= BCW'(1);
            is_fw_q    <= fw_code;
            is_mem_q   <= 1'b0;
            we_q       <= (lad_i == NIB_FW_WR);
            adr_q      <= '0;
            wdat_q     <= '0;
        end else begin
            case (state_q)
                ST_CTYPE: begin
                    is_mem_q   <= lad_i[2];
                    we_q       <= lad_i[1];
                    adr_left_q <= lad_i[2] ? ACW'(ADDR_NIBS) : ACW'(IO_NIBS);
                end
                ST_ADDR: begin
                    adr_q      <= {adr_q[ADDR_W-5:0], lad_i};
                    adr_left_q <= adr_left_q - ACW'(1);
                end
                ST_SIZE: begin
                    if (lad_i == 4'd1)      nbytes_q <= BCW'(2);
                    else if (lad_i == 4'd2) nbytes_q <= BCW'(4);
                    else                    nbytes_q <= BCW'(1);
                end
                ST_HDATA: begin
                    wdat_q[{dat_idx_q, 2'b00} +: 4] <= lad_i;
                    dat_idx_q <= last_nib ? '0 : dat_idx_q + DCW'(1);
                end
                ST_RDATA: begin
                    dat_idx_q <= dat_idx_q + DCW'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        lad_oe_o = 1'b0;
        lad_o    = NIB_TAR;
        unique case (state_q)
            ST_SYNC: begin
                lad_oe_o = 1'b1;
                if (!rsp_done_i)    lad_o = SYNC_LWAIT;
                else if (rsp_err_i) lad_o = SYNC_ERROR;
                else                lad_o = SYNC_READY;
            end
            ST_RDATA: begin
                lad_oe_o = 1'b1;
                lad_o    = rd_word_i[{dat_idx_q, 2'b00} +: 4];
            end
            ST_PTAR: begin
                lad_oe_o = 1'b1;
                lad_o    = NIB_TAR;
            end
            default: ;
        endcase
    end

    assign launch_o = (state_d == ST_HTAR1) && (state_q != ST_HTAR1);
    assign adr_o    = adr_q;
    assign wdat_o   = wdat_q;
    assign sel_o    = ~(4'b1111 << nbytes_q);
    assign tga_o    = is_fw_q ? TAG_FW : (is_mem_q ? TAG_MEM : TAG_IO);
    assign we_o     = we_q;

endmodule

// File: rtl/lpc_tgt_bridge.sv
module lpc_tgt_bridge
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IO_ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [3:0]        wb_sel_o,
    output logic [1:0]        wb_tga_o,
    output logic              wb_we_o,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    input  logic              wb_ack_i,
    input  logic              wb_err_i
);

    logic              launch;
    logic              rsp_done;
    logic              rsp_err;
    logic [DATA_W-1:0] rd_word;

    lpc_tgt_fsm #(
        .ADDR_W    (ADDR_W),
        .IO_ADDR_W (IO_ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_i),
        .lad_i      (lad_i),
        .rsp_done_i (rsp_done),
        .rsp_err_i  (rsp_err),
        .rd_word_i  (rd_word),
        .lad_o      (lad_o),
        .lad_oe_o   (lad_oe_o),
        .launch_o   (launch),
        .adr_o      (wb_adr_o),
        .wdat_o     (wb_dat_o),
        .sel_o      (wb_sel_o),
        .tga_o      (wb_tga_o),
        .we_o       (wb_we_o)
    );

    lpc_tgt_wbm #(
        .DW (DATA_W)
    ) u_wbm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (frame_i),
        .launch_i (launch),
        .ack_i    (wb_ack_i),
        .err_i    (wb_err_i),
        .dat_i    (wb_dat_i),
        .cyc_o    (wb_cyc_o),
        .stb_o    (wb_stb_o),
        .done_o   (rsp_done),
        .err_o    (rsp_err),
        .word_o   (rd_word)
    );

endmodule

// File: rtl/lpc_tgt_chk.sv
module lpc_tgt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_i,
    input logic        lad_oe_o,
    input logic        wb_cyc_o,
    input logic        wb_ack_i,
    input logic        wb_err_i,
    input logic [31:0] wb_adr_o,
    input logic [3:0]  wb_sel_o,
    input logic [1:0]  wb_tga_o
);

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (!lad_oe_o && !wb_cyc_o));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i && !wb_err_i && !frame_i) |=> wb_cyc_o);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && (wb_ack_i || wb_err_i)) |=> !wb_cyc_o);

    p_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i && !wb_err_i && !frame_i) |=>
            ($stable(wb_adr_o) && $stable(wb_sel_o) && $stable(wb_tga_o)));

    p_sel_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> (wb_sel_o == 4'b0001 || wb_sel_o == 4'b0011 || wb_sel_o == 4'b1111));

    p_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> (wb_tga_o != 2'b11));

endmodule

bind lpc_tgt_bridge lpc_tgt_chk u_chk (.*);

// File: tb/sim_lpc_tgt_bridge.sv
`timescale 1ns/1ps
module sim_lpc_tgt_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_i = 1'b0;
    logic [3:0]  lad_i = 4'hF;
    logic [3:0]  lad_o;
    logic        lad_oe_o;
    logic [31:0] wb_adr_o;
    logic [31:0] wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic [3:0]  wb_sel_o;
    logic [1:0]  wb_tga_o;
    logic        wb_we_o;
    logic        wb_cyc_o;
    logic        wb_stb_o;
    logic        wb_ack_i = 1'b0;
    logic        wb_err_i = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // responder and sync model state
    bit got_rsp;
    bit give_err;
    int ack_delay;
    int wait_cnt;
    bit last_ready;

    always #4 clk = ~clk;

    lpc_tgt_bridge u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame_i),
        .lad_i    (lad_i),
        .lad_o    (lad_o),
        .lad_oe_o (lad_oe_o),
        .wb_adr_o (wb_adr_o),
        .wb_dat_o (wb_dat_o),
        .wb_dat_i (wb_dat_i),
        .wb_sel_o (wb_sel_o),
        .wb_tga_o (wb_tga_o),
        .wb_we_o  (wb_we_o),
        .wb_cyc_o (wb_cyc_o),
        .wb_stb_o (wb_stb_o),
        .wb_ack_i (wb_ack_i),
        .wb_err_i (wb_err_i)
    );

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0: output enable low; mode 1: drive fix; mode 2: sync model
    task automatic step(input logic f, input logic [3:0] l, input int mode,
                        input logic [3:0] fix, input string req);
        bit rsp_now;
        logic       e_oe;
        logic [3:0] e_lad;
        frame_i = f;
        lad_i   = l;
        rsp_now = wb_ack_i || wb_err_i;
        @(posedge clk);
        #2;
        if (rsp_now) got_rsp = 1;
        wb_ack_i = 1'b0;
        wb_err_i = 1'b0;
        if (wb_cyc_o && wb_stb_o) begin
            if (wait_cnt == ack_delay) begin
                if (give_err) wb_err_i = 1'b1;
                else          wb_ack_i = 1'b1;
            end else begin
                wait_cnt++;
            end
        end
        e_oe  = (mode != 0);
        e_lad = fix;
        if (mode == 2) begin
            e_lad = got_rsp ? (give_err ? 4'b1010 : 4'b0000) : 4'b0110;
            last_ready = got_rsp;
        end
        n_cmp++;
        if (lad_oe_o !== e_oe || (e_oe && lad_o !== e_lad)) begin
            n_bad++;
            $display("FAIL %s: oe=%b lad=%h expected oe=%b lad=%h", req, lad_oe_o, lad_o, e_oe, e_lad);
        end
    endtask

    // kind: 0 memory, 1 I/O, 2 firmware
    task automatic xact(input int kind, input bit wr, input logic [31:0] addr, input int szc,
                        input logic [31:0] wd, input logic [31:0] rd, input int dly, input bit er,
                        input int cut_addr, input int cut_sync);
        int nbytes;
        int nnib;
        int guard;
        logic [31:0] exp_adr;
        logic [31:0] exp_wd;
        logic [3:0]  exp_sel;
        nbytes = 1;
        if (kind == 2 && szc == 1) nbytes = 2;
        if (kind == 2 && szc == 2) nbytes = 4;
        nnib      = (kind == 1) ? 4 : 8;
        got_rsp   = 0;
        wait_cnt  = 0;
        ack_delay = dly;
        give_err  = er;
        wb_dat_i  = rd;
        if (kind == 2) step(1'b1, wr ? 4'hE : 4'hD, 0, 4'h0, "R2");
        else           step(1'b1, 4'h0, 0, 4'h0, "R2");
        if (kind != 2) step(1'b0, {1'b0, kind == 0, wr, 1'b0}, 0, 4'h0, "R3");
        for (int i = 0; i < nnib; i++) begin
            if (i == cut_addr) begin
                step(1'b1, 4'h0, 0, 4'h0, "R11");
                expect_eq("R11 cyc after abort", {31'b0, wb_cyc_o}, 32'd0);
                return;
            end
            step(1'b0, addr[(nnib-1-i)*4 +: 4], 0, 4'h0, "R7");
        end
        if (kind == 2) step(1'b0, szc[3:0], 0, 4'h0, "R5");
        if (wr) begin
            for (int b = 0; b < nbytes; b++) begin
                for (int n = 0; n < 2; n++) begin
                    step(1'b0, wd[b*8+n*4 +: 4], 0, 4'h0, "R6");
                end
            end
        end
        exp_adr = (kind == 1) ? {16'h0, addr[15:0]} : addr;
        exp_sel = (nbytes == 4) ? 4'b1111 : (nbytes == 2) ? 4'b0011 : 4'b0001;
        exp_wd  = (nbytes == 4) ? wd : (nbytes == 2) ? {16'h0, wd[15:0]} : {24'h0, wd[7:0]};
        expect_eq("R7 cyc raised", {30'b0, wb_cyc_o, wb_stb_o}, 32'd3);
        expect_eq("R4 address", wb_adr_o, exp_adr);
        expect_eq("R3 tag", {30'b0, wb_tga_o}, (kind == 2) ? 32'd2 : (kind == 0) ? 32'd0 : 32'd1);
        expect_eq("R3 write enable", {31'b0, wb_we_o}, {31'b0, wr});
        expect_eq("R5 byte select", {28'b0, wb_sel_o}, {28'b0, exp_sel});
        if (wr) expect_eq("R6 write data", wb_dat_o, exp_wd);
        step(1'b0, 4'hF, 0, 4'h0, "R7");
        step(1'b0, 4'hF, 2, 4'h0, "R8");
        guard = 0;
        while (!last_ready && guard < 64) begin
            if (guard == cut_sync) begin
                step(1'b1, 4'hF, 0, 4'h0, "R11");
                expect_eq("R11 cyc dropped", {31'b0, wb_cyc_o}, 32'd0);
                step(1'b0, 4'hF, 0, 4'h0, "R11");
                return;
            end
            step(1'b0, 4'hF, 2, 4'h0, "R8");
            guard++;
        end
        if (!er && !wr) begin
            for (int b = 0; b < nbytes; b++) begin
                step(1'b0, 4'hF, 1, rd[b*8 +: 4], "R9");
                step(1'b0, 4'hF, 1, rd[b*8+4 +: 4], "R9");
                if (b < nbytes - 1) step(1'b0, 4'hF, 2, 4'h0, "R9");
            end
        end
        step(1'b0, 4'hF, 1, 4'hF, "R10");
        step(1'b0, 4'hF, 0, 4'h0, "R10");
        expect_eq("R7 cyc idle at end", {31'b0, wb_cyc_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        expect_eq("R1 reset oe/cyc/stb", {29'b0, lad_oe_o, wb_cyc_o, wb_stb_o}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        expect_eq("R1 after release", {29'b0, lad_oe_o, wb_cyc_o, wb_stb_o}, 32'd0);

        // non-start nibbles leave the block idle
        step(1'b1, 4'hF, 0, 4'h0, "R2");
        step(1'b1, 4'h5, 0, 4'h0, "R2");
        step(1'b0, 4'h0, 0, 4'h0, "R2");
        step(1'b0, 4'hF, 0, 4'h0, "R2");
        expect_eq("R2 no cycle", {31'b0, wb_cyc_o}, 32'd0);

        xact(1, 1'b1, 32'h1234ABCD, 0, 32'h0000005A, 32'h0, 0, 1'b0, -1, -1);
        xact(1, 1'b0, 32'h00000060, 0, 32'h0, 32'hFFFFFFC3, 3, 1'b0, -1, -1);
        xact(0, 1'b1, 32'hFEDCBA98, 0, 32'hAABBCC7E, 32'h0, 1, 1'b0, -1, -1);
        xact(0, 1'b0, 32'h000F0010, 0, 32'h0, 32'h12345696, 5, 1'b0, -1, -1);
        xact(2, 1'b0, 32'h80001234, 2, 32'h0, 32'h89ABCDEF, 2, 1'b0, -1, -1);
        xact(2, 1'b1, 32'h00C0FFEE, 1, 32'h1234BEEF, 32'h0, 0, 1'b0, -1, -1);
        xact(2, 1'b0, 32'h76543210, 1, 32'h0, 32'h11223344, 1, 1'b0, -1, -1);
        xact(2, 1'b1, 32'hDEADBEE0, 2, 32'hCAFEF00D, 32'h0, 4, 1'b0, -1, -1);
        xact(2, 1'b0, 32'h00000007, 7, 32'h0, 32'h000000A5, 0, 1'b0, -1, -1);
        xact(0, 1'b0, 32'h00001000, 0, 32'h0, 32'h00000055, 2, 1'b1, -1, -1);
        xact(1, 1'b1, 32'h000003F8, 0, 32'h00000011, 32'h0, 0, 1'b1, -1, -1);

        // aborts: mid-address with a fresh start, then mid-sync with a stop
        xact(0, 1'b0, 32'h11111111, 0, 32'h0, 32'h0, 0, 1'b0, 3, -1);
        xact(1, 1'b1, 32'h00002468, 0, 32'h0000003C, 32'h0, 2, 1'b0, -1, -1);
        xact(0, 1'b0, 32'h22222222, 0, 32'h0, 32'h0, 40, 1'b0, -1, 2);
        xact(1, 1'b0, 32'h00000080, 0, 32'h0, 32'h0000007B, 1, 1'b0, -1, -1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule